// File: doc/BRIEF.md
# GPIO Pad Control Register Bank

This block holds the configuration and data registers for a small group of general-purpose pins and turns them into pad controls. Every pin owns two bus words: a control word that chooses which function owns the pad, the pull behaviour, the drive-strength code and whether the pad is driven, and an I/O word that carries the value to drive and the synchronized level seen on the pad. A function code of zero gives the pad to the register-driven GPIO path. Any other code hands the pad's data and enable to one of the alternate-function lanes that peripherals supply.

The block contains a simple behavioural pad model. It resolves the pad level from the block's own driver, an external driver and the selected pull or keeper. That level then passes through a two-flop synchronizer before software or other logic can see it. Software reaches the registers over a word-addressed bus. A write takes effect at the next clock edge, and read data appears one cycle after the read is requested.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset, every control and I/O field is zero. The pad is therefore undriven (GPIO input), with no pull and drive code 0, and read data is 0.
- R2: Bus address bit 0 picks the word (0 = control, 1 = I/O) and the remaining upper bits pick the pin. The control word packs function code in [2:0], pull code in [4:3], drive code in [7:5] and output enable in [8]. It reads back as written, with all higher bits reading 0. Read data is registered one cycle after `bus_rd_en` and holds while no read is requested.
- R3: Pull code 0 asserts none of `pad_pull_up`, `pad_pull_dn` and `pad_keep`. Code 1 asserts only `pad_pull_dn`, code 2 only `pad_keep`, and code 3 only `pad_pull_up`.
- R4: `pad_drive` carries the 3-bit drive code of each pin unchanged. Code n stands for (n+1)*2 mA, so 0..7 span 2..16 mA.
- R5: With function code 0, a pin's `pad_out` equals its I/O output bit and `pad_oe` equals its output-enable bit. With code k in 1..7, both come from alternate lane k-1 of that pin, at bit pin*7+k-1 of `alt_dout` and `alt_oe`.
- R6: `pin_in_sync` and I/O word bit 1 show the pad level as it was two clock edges earlier.
- R7: The resolved `pad_level` follows a fixed priority. If the pad is driven, it is `pad_out`. Otherwise, if `ext_drv_en` is set, it is `ext_drv_val`. Otherwise pull-up gives 1, keeper gives the level of the previous cycle, and pull-down or no pull give 0.
- R8: I/O word bit 0 is the output value and can be read and written. Bit 1 is read-only, and writes to it have no effect.
- R9: When the output value is written before output enable is set, the pad drives the new value in the very cycle `pad_oe` rises.
- R10: When a read and a write hit the same word in the same cycle, the read returns the content from before the write, and the next read returns the new content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address {pin, word select} |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| alt_dout | input | NUM_PINS*NUM_ALT | Alternate-function output data lanes |
| alt_oe | input | NUM_PINS*NUM_ALT | Alternate-function output enable lanes |
| ext_drv_en | input | NUM_PINS | External driver active on the pad (model) |
| ext_drv_val | input | NUM_PINS | Level driven by the external driver |
| pad_out | output | NUM_PINS | Pad output data |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pull_up | output | NUM_PINS | Pull-up enable |
| pad_pull_dn | output | NUM_PINS | Pull-down enable |
| pad_keep | output | NUM_PINS | Keeper enable |
| pad_drive | output | NUM_PINS*3 | Drive-strength code per pin |
| pad_level | output | NUM_PINS | Resolved pad level |
| pin_in_sync | output | NUM_PINS | Synchronized pad input |

## Verification
Two functions can land in the same cycle. A bus read of a word and a bus write to that same word can coincide. A read of the I/O word can also coincide with the synchronizer shifting a new pad level into the input bit. The bench provokes the first by asserting both strobes on one address and expects the old word, followed by the new word on the next read. It provokes the second by toggling the external driver around I/O reads and random traffic, with a behavioural model judging every cycle which sample the read must return.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int FUNC_W = 3;
  localparam int DRV_W  = 3;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_KEEP = 2'd2,
    PULL_UP   = 2'd3
  } pull_e;

  // MSB first: bit 8 oe, [7:5] drive, [4:3] pull, [2:0] function
  typedef struct packed {
    logic              oe;
    logic [DRV_W-1:0]  drive;
    pull_e             pull;
    logic [FUNC_W-1:0] func;
  } pin_ctl_t;

  localparam int CTL_W = $bits(pin_ctl_t);
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] in_sync,
  output logic [DATA_W-1:0]   rdata,
  output pin_ctl_t            ctl_q [NUM_PINS],
  output logic [NUM_PINS-1:0] out_q
);
  localparam int PIN_W = ADDR_W - 1;

  logic [PIN_W-1:0]    pin_sel;
  logic                word_sel;
  logic                hit;
  logic                ctl_en;
  logic                out_en;
  pin_ctl_t            ctl_d [NUM_PINS];
  logic [NUM_PINS-1:0] out_d;
  logic [DATA_W-1:0]   rdata_d;
  logic                unused_wdata;

  assign pin_sel      = addr[ADDR_W-1:1];
  assign word_sel     = addr[0];
  assign hit          = 32'(pin_sel) < NUM_PINS;
  assign ctl_en       = wr_en && hit && !word_sel;
  assign out_en       = wr_en && hit && word_sel;
  assign unused_wdata = ^wdata[DATA_W-1:CTL_W];

  // next state
  always_comb begin
    ctl_d = ctl_q;
    out_d = out_q;
    if (ctl_en) ctl_d[pin_sel] = pin_ctl_t'(wdata[CTL_W-1:0]);
    if (out_en) out_d[pin_sel] = wdata[0];
  end

  // read mux over current (pre-write) state
  always_comb begin
    rdata_d = '0;
    if (hit) begin
      if (word_sel) rdata_d = {{(DATA_W-2){1'b0}}, in_sync[pin_sel], out_q[pin_sel]};
      else          rdata_d = {{(DATA_W-CTL_W){1'b0}}, ctl_q[pin_sel]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{default: '0};
      out_q <= '0;
      rdata <= '0;
    end else begin
      if (ctl_en) ctl_q <= ctl_d;
      if (out_en) out_q <= out_d;
      if (rd_en)  rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_pad_pkg::*;
#(
  parameter int NUM_ALT = 7
) (
  input  pin_ctl_t           ctl,
  input  logic               out_val,
  input  logic [NUM_ALT-1:0] alt_dout,
  input  logic [NUM_ALT-1:0] alt_oe,
  output logic               pad_out,
  output logic               pad_oe,
  output logic               pull_up,
  output logic               pull_dn,
  output logic               keep,
  output logic [DRV_W-1:0]   drive
);
  logic [FUNC_W-1:0] lane;
  logic              lane_ok;

  assign lane    = ctl.func - FUNC_W'(1);
  assign lane_ok = 32'(ctl.func) <= NUM_ALT;

  always_comb begin
    if (ctl.func == '0) begin
      pad_out = out_val;
      pad_oe  = ctl.oe;
    end else if (lane_ok) begin
      pad_out = alt_dout[lane];
      pad_oe  = alt_oe[lane];
    end else begin
      pad_out = 1'b0;
      pad_oe  = 1'b0;
    end
  end

  assign pull_up = (ctl.pull == PULL_UP);
  assign pull_dn = (ctl.pull == PULL_DOWN);
  assign keep    = (ctl.pull == PULL_KEEP);
  assign drive   = ctl.drive;
endmodule

// File: rtl/gpio_pad_model.sv
module gpio_pad_model (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_oe,
  input  logic drv_val,
  input  logic pull_up,
  input  logic keep,
  input  logic ext_en,
  input  logic ext_val,
  output logic level,
  output logic in_sync
);
  logic keep_q;
  logic sync1_q;
  logic sync2_q;

  always_comb begin
    if (drv_oe)       level = drv_val;
    else if (ext_en)  level = ext_val;
    else if (pull_up) level = 1'b1;
    else if (keep)    level = keep_q;
    else              level = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keep_q  <= 1'b0;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      keep_q  <= level;
      sync1_q <= level;
      sync2_q <= sync1_q;
    end
  end

  assign in_sync = sync2_q;
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_pad_pkg::*;
#(
  parameter  int NUM_PINS = 4,
  parameter  int NUM_ALT  = 7,
  parameter  int DATA_W   = 16,
  localparam int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int ADDR_W   = PIN_W + 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_wr_en,
  input  logic                        bus_rd_en,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  input  logic [NUM_PINS*NUM_ALT-1:0] alt_dout,
  input  logic [NUM_PINS*NUM_ALT-1:0] alt_oe,
  input  logic [NUM_PINS-1:0]         ext_drv_en,
  input  logic [NUM_PINS-1:0]         ext_drv_val,
  output logic [NUM_PINS-1:0]         pad_out,
  output logic [NUM_PINS-1:0]         pad_oe,
  output logic [NUM_PINS-1:0]         pad_pull_up,
  output logic [NUM_PINS-1:0]         pad_pull_dn,
  output logic [NUM_PINS-1:0]         pad_keep,
  output logic [NUM_PINS*DRV_W-1:0]   pad_drive,
  output logic [NUM_PINS-1:0]         pad_level,
  output logic [NUM_PINS-1:0]         pin_in_sync
);
  logic                rst_n_int;
  pin_ctl_t            ctl_q [NUM_PINS];
  logic [NUM_PINS-1:0] out_q;

  gpio_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gpio_pad_regs #(
    .NUM_PINS (NUM_PINS),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (bus_wr_en),
    .rd_en   (bus_rd_en),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .in_sync (pin_in_sync),
    .rdata   (bus_rdata),
    .ctl_q   (ctl_q),
    .out_q   (out_q)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_mux #(.NUM_ALT(NUM_ALT)) u_mux (
      .ctl      (ctl_q[p]),
      .out_val  (out_q[p]),
      .alt_dout (alt_dout[p*NUM_ALT +: NUM_ALT]),
      .alt_oe   (alt_oe[p*NUM_ALT +: NUM_ALT]),
      .pad_out  (pad_out[p]),
      .pad_oe   (pad_oe[p]),
      .pull_up  (pad_pull_up[p]),
      .pull_dn  (pad_pull_dn[p]),
      .keep     (pad_keep[p]),
      .drive    (pad_drive[p*DRV_W +: DRV_W])
    );

    gpio_pad_model u_pad (
      .clk     (clk),
      .rst_n   (rst_n_int),
      .drv_oe  (pad_oe[p]),
      .drv_val (pad_out[p]),
      .pull_up (pad_pull_up[p]),
      .keep    (pad_keep[p]),
      .ext_en  (ext_drv_en[p]),
      .ext_val (ext_drv_val[p]),
      .level   (pad_level[p]),
      .in_sync (pin_in_sync[p])
    );
  end
endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk #(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_rd_en,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [NUM_PINS-1:0] ext_drv_en,
  input logic [NUM_PINS-1:0] pad_out,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_PINS-1:0] pad_pull_up,
  input logic [NUM_PINS-1:0] pad_pull_dn,
  input logic [NUM_PINS-1:0] pad_keep,
  input logic [NUM_PINS-1:0] pad_level,
  input logic [NUM_PINS-1:0] pin_in_sync
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cyc_q <= 2'd0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (pad_oe == '0 && bus_rdata == '0); // R1
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != 2'd0 && !$past(bus_rd_en)) |-> $stable(bus_rdata)); // R2

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> (pin_in_sync == $past(pad_level, 2))); // R6

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
    AST_PULL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pad_pull_up[p], pad_pull_dn[p], pad_keep[p]})); // R3

    AST_DRIVEN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[p] |-> (pad_level[p] == pad_out[p])); // R7

    AST_KEEPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q != 2'd0 && pad_keep[p] && !pad_oe[p] && !ext_drv_en[p])
        |-> (pad_level[p] == $past(pad_level[p]))); // R7
  end
endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_rd_en   (bus_rd_en),
  .bus_rdata   (bus_rdata),
  .ext_drv_en  (ext_drv_en),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .pad_pull_up (pad_pull_up),
  .pad_pull_dn (pad_pull_dn),
  .pad_keep    (pad_keep),
  .pad_level   (pad_level),
  .pin_in_sync (pin_in_sync)
);

// File: tb/gpio_pad_bank_tb_top.sv
module gpio_pad_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int ALT = 7;
  localparam int DW  = 16;
  localparam int AW  = 3;

  logic            clk;
  logic            rst_n;
  logic            bus_wr_en, bus_rd_en;
  logic [AW-1:0]   bus_addr;
  logic [DW-1:0]   bus_wdata;
  logic [DW-1:0]   bus_rdata;
  logic [N*ALT-1:0] alt_dout, alt_oe;
  logic [N-1:0]    ext_drv_en, ext_drv_val;
  logic [N-1:0]    pad_out, pad_oe, pad_pull_up, pad_pull_dn, pad_keep, pad_level, pin_in_sync;
  logic [N*3-1:0]  pad_drive;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // reference model state
  int m_func [N], m_pull [N], m_drv [N], m_oe [N], m_out [N];
  int m_s1 [N], m_s2 [N], m_keep [N];
  int m_rdata;

  gpio_pad_bank #(.NUM_PINS(N), .NUM_ALT(ALT), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .alt_dout(alt_dout), .alt_oe(alt_oe), .ext_drv_en(ext_drv_en),
    .ext_drv_val(ext_drv_val), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn), .pad_keep(pad_keep),
    .pad_drive(pad_drive), .pad_level(pad_level), .pin_in_sync(pin_in_sync)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int m_oe_eff(int p);
    if (m_func[p] == 0) return m_oe[p];
    return int'(alt_oe[p*ALT + m_func[p] - 1]);
  endfunction

  function automatic int m_out_eff(int p);
    if (m_func[p] == 0) return m_out[p];
    return int'(alt_dout[p*ALT + m_func[p] - 1]);
  endfunction

  function automatic int m_level(int p);
    if (m_oe_eff(p) != 0) return m_out_eff(p);
    if (ext_drv_en[p])    return int'(ext_drv_val[p]);
    if (m_pull[p] == 3)   return 1;
    if (m_pull[p] == 2)   return m_keep[p];
    return 0;
  endfunction

  task automatic model_tick();
    int lv [N];
    int pin;
    pin = int'(bus_addr) >> 1;
    for (int p = 0; p < N; p++) lv[p] = m_level(p);
    if (bus_rd_en) begin
      if (bus_addr[0]) m_rdata = m_out[pin] | (m_s2[pin] << 1);
      else m_rdata = m_func[pin] | (m_pull[pin] << 3) | (m_drv[pin] << 5) | (m_oe[pin] << 8);
    end
    for (int p = 0; p < N; p++) begin
      m_s2[p] = m_s1[p];
      m_s1[p] = lv[p];
      m_keep[p] = lv[p];
    end
    if (bus_wr_en) begin
      if (bus_addr[0]) m_out[pin] = int'(bus_wdata[0]);
      else begin
        m_func[pin] = int'(bus_wdata[2:0]);
        m_pull[pin] = int'(bus_wdata[4:3]);
        m_drv[pin]  = int'(bus_wdata[7:5]);
        m_oe[pin]   = int'(bus_wdata[8]);
      end
    end
  endtask

  task automatic compare_all();
    for (int p = 0; p < N; p++) begin
      chk("R5 pad_oe", int'(pad_oe[p]), m_oe_eff(p));
      chk("R5 pad_out", int'(pad_out[p]), m_out_eff(p));
      chk("R3 pull_up", int'(pad_pull_up[p]), int'(m_pull[p] == 3));
      chk("R3 pull_dn", int'(pad_pull_dn[p]), int'(m_pull[p] == 1));
      chk("R3 keep", int'(pad_keep[p]), int'(m_pull[p] == 2));
      chk("R4 drive", int'(pad_drive[p*3 +: 3]), m_drv[p]);
      chk("R7 level", int'(pad_level[p]), m_level(p));
      chk("R6 sync", int'(pin_in_sync[p]), m_s2[p]);
    end
    chk("R2 rdata", int'(bus_rdata), m_rdata);
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic bus(bit wr, bit rd, int addr, int data);
    bus_wr_en = wr;
    bus_rd_en = rd;
    bus_addr  = AW'(addr);
    bus_wdata = DW'(data);
    step();
    bus_wr_en = 1'b0;
    bus_rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bus_wr_en = 1'b0; bus_rd_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    alt_dout = '0; alt_oe = '0; ext_drv_en = '0; ext_drv_val = '0;
    m_rdata = 0;
    for (int p = 0; p < N; p++) begin
      m_func[p] = 0; m_pull[p] = 0; m_drv[p] = 0; m_oe[p] = 0; m_out[p] = 0;
      m_s1[p] = 0; m_s2[p] = 0; m_keep[p] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();

    // R1: reset state
    chk("R1 pad_oe", int'(pad_oe), 0);
    chk("R1 pad_drive", int'(pad_drive), 0);
    chk("R1 pulls", int'({pad_pull_up, pad_pull_dn, pad_keep}), 0);
    bus(0, 1, 4, 0);
    chk("R1 ctl read", int'(bus_rdata), 0);

    // R2: control readback and upper bits
    bus(1, 0, 0, 168);
    bus(0, 1, 0, 0);
    chk("R2 ctl pin0", int'(bus_rdata), 168);
    bus(1, 0, 2, 16'hFFFF);
    bus(0, 1, 2, 0);
    chk("R2 ctl pin1 upper", int'(bus_rdata), 16'h01FF);
    step();
    chk("R2 rdata hold", int'(bus_rdata), 16'h01FF);

    // R3: pull decoding on pin2
    for (int k = 0; k < 4; k++) begin
      bus(1, 0, 4, k << 3);
      chk("R3 up", int'(pad_pull_up[2]), int'(k == 3));
      chk("R3 dn", int'(pad_pull_dn[2]), int'(k == 1));
      chk("R3 keep", int'(pad_keep[2]), int'(k == 2));
    end

    // R4: drive codes on pin3
    for (int k = 0; k < 8; k++) begin
      bus(1, 0, 6, k << 5);
      chk($sformatf("R4 code for %0d mA", (k + 1) * 2), int'(pad_drive[9 +: 3]), k);
    end

    // R5: function select on pin0
    alt_dout = 28'h5A5A5A5;
    alt_oe   = 28'hC3C3C3C;
    bus(1, 0, 1, 1);
    for (int k = 0; k < 8; k++) begin
      bus(1, 0, 0, k | (1 << 8));
      if (k == 0) begin
        chk("R5 gpio oe", int'(pad_oe[0]), 1);
        chk("R5 gpio out", int'(pad_out[0]), 1);
      end else begin
        chk("R5 alt oe", int'(pad_oe[0]), int'(alt_oe[k-1]));
        chk("R5 alt out", int'(pad_out[0]), int'(alt_dout[k-1]));
      end
    end
    bus(1, 0, 0, 0);
    bus(1, 0, 1, 0);

    // R6: synchronizer delay on pin2 via external driver
    bus(1, 0, 4, 0);
    ext_drv_en[2] = 1'b1;
    ext_drv_val[2] = 1'b0;
    repeat (3) step();
    ext_drv_val[2] = 1'b1;
    step();
    chk("R6 after one edge", int'(pin_in_sync[2]), 0);
    step();
    chk("R6 after two edges", int'(pin_in_sync[2]), 1);
    bus(0, 1, 5, 0);
    chk("R6 io bit1", int'(bus_rdata[1]), 1);
    ext_drv_val[2] = 1'b0;
    repeat (3) step();
    ext_drv_en[2] = 1'b0;
    step();

    // R7: keeper, pulls and priority on pin3
    bus(1, 0, 7, 1);
    bus(1, 0, 6, (2 << 3) | (1 << 8));
    chk("R7 driven", int'(pad_level[3]), 1);
    bus(1, 0, 6, 2 << 3);
    repeat (3) begin
      step();
      chk("R7 keeper holds", int'(pad_level[3]), 1);
    end
    ext_drv_en[3] = 1'b1;
    ext_drv_val[3] = 1'b0;
    step();
    chk("R7 external over keeper", int'(pad_level[3]), 0);
    ext_drv_en[3] = 1'b0;
    step();
    chk("R7 keeper holds last", int'(pad_level[3]), 0);
    bus(1, 0, 6, 3 << 3);
    chk("R7 pull up", int'(pad_level[3]), 1);
    bus(1, 0, 6, 1 << 3);
    chk("R7 pull down", int'(pad_level[3]), 0);

    // R8: I/O bit1 read-only on pin0
    bus(1, 0, 1, 2);
    repeat (2) step();
    bus(0, 1, 1, 0);
    chk("R8 bit1 write ignored", int'(bus_rdata), 0);
    bus(1, 0, 1, 3);
    bus(0, 1, 1, 0);
    chk("R8 bit0 written", int'(bus_rdata), 1);
    bus(1, 0, 1, 0);

    // R9: value before enable on pin2
    bus(1, 0, 4, 0);
    bus(1, 0, 5, 1);
    chk("R9 oe still low", int'(pad_oe[2]), 0);
    bus(1, 0, 4, 1 << 8);
    chk("R9 oe rises", int'(pad_oe[2]), 1);
    chk("R9 no stale value", int'(pad_out[2]), 1);

    // R10: read and write same word same cycle
    bus(1, 0, 0, 16'h00A5);
    bus(1, 1, 0, 16'h0133);
    chk("R10 old content", int'(bus_rdata), 16'h00A5);
    bus(0, 1, 0, 0);
    chk("R10 new content", int'(bus_rdata), 16'h0133);

    // mixed traffic, model compared every cycle
    for (int i = 0; i < 200; i++) begin
      ext_drv_en  = N'($urandom);
      ext_drv_val = N'($urandom);
      if (i % 17 == 0) begin
        alt_dout = (N*ALT)'($urandom);
        alt_oe   = (N*ALT)'($urandom);
      end
      bus(1'($urandom), 1'($urandom), int'($urandom % 8), int'($urandom % 65536));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule